// File: doc/BRIEF.md
# Phase-Change Memory Bank Write Cancel and Pause Scheduler

This block schedules requests for a single bank of a phase-change memory, a technology in which a write costs far more time than a read. Writes enter a small buffer at once so the requester never stalls on them. Reads are held in a single slot and always take precedence over buffered writes. A buffered write only reaches the bank when no read needs it. The write then runs as a series of program-and-verify iterations, each of fixed length.

A read can interrupt a write that is already running, in one of two ways. If the read needs the bank and arrives early in the write, measured against a threshold that software may change at run time, the write is aborted and the read goes first. The aborted write stays in the buffer and starts again from iteration zero. If the read arrives later, or if cancelling is not allowed at that moment, the write pauses at the end of its current iteration. The read is served, and the write resumes with its count of completed iterations intact.

Cancelling is refused in two cases: when the buffer is more than three-quarters full, and when the write has already used up its cancel allowance. In both cases pausing is still allowed. A read whose address is present in the write buffer gets the newest buffered data back and never touches the bank.

Top module: `pcm_wsched`

## Requirements
- R1: Only one read is held at a time: `rd_ready` is low from the handshake until that read's response. Responses appear in the order the reads were accepted. A read that is not in the buffer returns the data from `bank_rdata`, with `rsp_from_buf`=0.
- R2: A read whose address matches a buffered write is answered from the buffer, with the data of the most recently accepted matching write and `rsp_from_buf`=1. No bank command is issued for it.
- R3: Up to `WB_DEPTH` writes are accepted without waiting. `wr_ready` is low while the buffer holds `WB_DEPTH` entries.
- R4: A write iteration command (`cmd_type`=1) is never issued while a read that needs the bank is pending. Such a read is therefore answered before the write it interrupts completes.
- R5: A write completes after `ITERS` uninterrupted iteration commands. Completion is a one-cycle `wr_done` pulse carrying the write's address. Writes complete in the order they were accepted.
- R6: A read that needs the bank and arrives while the running write has spent fewer than `cancel_win` cycles in service causes an abort command (`cmd_type`=2). The read is then served, and the write reruns all `ITERS` iterations from the start.
- R7: No bank command is issued in the cycle that follows an abort command.
- R8: A read that arrives when cancelling is not allowed is served after the current iteration ends. The write then resumes, so its total number of iteration commands stays `ITERS`.
- R9: The cancel window `cancel_win` may change at run time. A value of 0 disables cancelling altogether.
- R10: While the buffer holds more than three-quarters of `WB_DEPTH` entries, no abort is issued.
- R11: A single write is aborted at most `MAX_CANCEL` times. After that it can only be paused.
- R12: A read command (`cmd_type`=0) is followed by no command in the next cycle. Its response appears exactly `RD_LAT` cycles after the command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read slot free |
| rd_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | DW | Read response data |
| rsp_from_buf | output | 1 | Response served from the write buffer |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write buffer has room |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| cancel_win | input | WIN_W | Cancel window in cycles, 0 disables |
| cmd_valid | output | 1 | Bank command valid |
| cmd_type | output | 2 | 0 read, 1 write iteration, 2 abort |
| cmd_addr | output | AW | Bank command address |
| cmd_data | output | DW | Write data for an iteration command |
| bank_rdata | input | DW | Bank read data, valid from the cycle after a read command |
| wr_done | output | 1 | Write completion pulse |
| wr_done_addr | output | AW | Address of the completed write |

## Verification
The bench builds the block with its default parameters: a four-entry buffer, four iterations of eight cycles, a read latency of two and a cancel allowance of two. With a buffer this shallow, a single burst of four writes crosses the three-quarters threshold. The allowance is small enough that a chain of four interrupting reads runs through both cancels and then falls back to pauses. The bench sweeps sixteen bank addresses for read data and latency. It also drives the window through 0, a small value and a large value, so that the same write pattern produces an abort in one case and a pause in another. The expected counts of iteration and abort commands follow directly from `ITERS` and `MAX_CANCEL`.

// File: rtl/pcm_ws_pkg.sv
package pcm_ws_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_ITER  = 2'd1,
    CMD_ABORT = 2'd2
  } bank_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_ABORT
  } sched_st_e;
endpackage

// File: rtl/pcm_ws_wbuf.sv
module pcm_ws_wbuf #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wp] <= push_addr;
      data_mem[wp] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head_addr = addr_mem[rp];
  assign head_data = data_mem[rp];

  // Scan oldest to newest so the youngest match wins.
  always_comb begin
    logic [PW:0] slot;
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = {1'b0, rp} + (PW+1)'(i);
      if (slot >= (PW+1)'(DEPTH)) slot = slot - (PW+1)'(DEPTH);
      if ((CW'(i) < count) && (addr_mem[slot[PW-1:0]] == look_addr)) begin
        look_hit  = 1'b1;
        look_data = data_mem[slot[PW-1:0]];
      end
    end
  end
endmodule

// File: rtl/pcm_wsched.sv
module pcm_wsched
  import pcm_ws_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int WB_DEPTH   = 4,
  parameter int ITERS      = 4,
  parameter int ITER_CYC   = 8,
  parameter int RD_LAT     = 2,
  parameter int MAX_CANCEL = 2,
  parameter int WIN_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_from_buf,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [WIN_W-1:0] cancel_win,
  output logic             cmd_valid,
  output logic [1:0]       cmd_type,
  output logic [AW-1:0]    cmd_addr,
  output logic [DW-1:0]    cmd_data,
  input  logic [DW-1:0]    bank_rdata,
  output logic             wr_done,
  output logic [AW-1:0]    wr_done_addr
);
  localparam int CW  = $clog2(WB_DEPTH + 1);
  localparam int ITW = $clog2(ITERS + 1);
  localparam int CYW = $clog2(ITER_CYC + RD_LAT + 2);
  localparam int KW  = $clog2(MAX_CANCEL + 1);

  sched_st_e       st;
  logic [CYW-1:0]  cnt;
  logic [ITW-1:0]  iters_done;
  logic [WIN_W-1:0] elapsed;
  logic [KW-1:0]   cancels;
  logic            rd_held;
  logic [AW-1:0]   rd_addr_q;

  logic [AW-1:0]   head_addr;
  logic [DW-1:0]   head_data;
  logic [CW-1:0]   wb_count;
  logic            hit;
  logic [DW-1:0]   hit_data;

  logic push, pop_now, hit_now, miss_pend, near_full, can_cancel, do_cancel, last_iter;

  assign rd_ready   = !rd_held;
  assign wr_ready   = wb_count < CW'(WB_DEPTH);
  assign push       = wr_valid && wr_ready;
  assign hit_now    = rd_held && hit && (st != ST_READ);
  assign miss_pend  = rd_held && !hit && (st != ST_READ);
  assign near_full  = {wb_count, 2'b00} > (CW+2)'(3 * WB_DEPTH);
  assign can_cancel = !near_full && (cancels < KW'(MAX_CANCEL)) && (elapsed < cancel_win);
  assign do_cancel  = (st == ST_WRITE) && miss_pend && can_cancel;
  assign last_iter  = iters_done == ITW'(ITERS - 1);
  assign pop_now    = (st == ST_WRITE) && !do_cancel && (cnt == '0) && last_iter;

  pcm_ws_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop_now),
    .head_addr (head_addr),
    .head_data (head_data),
    .count     (wb_count),
    .look_addr (rd_addr_q),
    .look_hit  (hit),
    .look_data (hit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      iters_done   <= '0;
      elapsed      <= '0;
      cancels      <= '0;
      rd_held      <= 1'b0;
      rd_addr_q    <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_from_buf <= 1'b0;
      cmd_valid    <= 1'b0;
      cmd_type     <= CMD_READ;
      cmd_addr     <= '0;
      cmd_data     <= '0;
      wr_done      <= 1'b0;
      wr_done_addr <= '0;
    end else begin
      cmd_valid <= 1'b0;
      rsp_valid <= 1'b0;
      wr_done   <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_held   <= 1'b1;
        rd_addr_q <= rd_addr;
      end
      if (hit_now) begin
        rsp_valid    <= 1'b1;
        rsp_data     <= hit_data;
        rsp_from_buf <= 1'b1;
        rd_held      <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (miss_pend) begin
            cmd_valid <= 1'b1;
            cmd_type  <= CMD_READ;
            cmd_addr  <= rd_addr_q;
            cmd_data  <= '0;
            cnt       <= CYW'(RD_LAT - 1);
            st        <= ST_READ;
          end else if (!hit_now && wb_count != '0) begin
            cmd_valid <= 1'b1;
            cmd_type  <= CMD_ITER;
            cmd_addr  <= head_addr;
            cmd_data  <= head_data;
            cnt       <= CYW'(ITER_CYC - 1);
            st        <= ST_WRITE;
            if (iters_done == '0) elapsed <= '0;
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            rsp_valid    <= 1'b1;
            rsp_data     <= bank_rdata;
            rsp_from_buf <= 1'b0;
            rd_held      <= 1'b0;
            st           <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (elapsed != '1) elapsed <= elapsed + 1'b1;
          if (do_cancel) begin
            cmd_valid  <= 1'b1;
            cmd_type   <= CMD_ABORT;
            cmd_addr   <= head_addr;
            cmd_data   <= '0;
            iters_done <= '0;
            cancels    <= cancels + 1'b1;
            cnt        <= CYW'(1);
            st         <= ST_ABORT;
          end else if (cnt == '0) begin
            st <= ST_IDLE;
            if (last_iter) begin
              wr_done      <= 1'b1;
              wr_done_addr <= head_addr;
              iters_done   <= '0;
              cancels      <= '0;
            end else begin
              iters_done <= iters_done + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcm_wsched_chk.sv
module pcm_wsched_chk #(
  parameter int MAX_CANCEL = 2,
  parameter int KW         = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_type,
  input logic          rsp_valid,
  input logic          miss_pend,
  input logic          near_full,
  input logic [KW-1:0] cancels
);
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd2) |=> !cmd_valid); // R7
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd0) |=> !cmd_valid); // R12
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd1) |-> !$past(miss_pend)); // R4
  AST_CANCEL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd2) |-> ($past(cancels) < KW'(MAX_CANCEL))); // R11
  AST_NO_CANCEL_FULL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_type == 2'd2) |-> !$past(near_full)); // R10
  AST_RSP_SPACED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R1
endmodule

bind pcm_wsched pcm_wsched_chk #(.MAX_CANCEL(MAX_CANCEL), .KW(KW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_type  (cmd_type),
  .rsp_valid (rsp_valid),
  .miss_pend (miss_pend),
  .near_full (near_full),
  .cancels   (cancels)
);

// File: tb/sim_pcm_wsched.sv
`timescale 1ns/1ps
module sim_pcm_wsched;
  localparam int AW = 8, DW = 8, ITERS = 4, RD_LAT = 2, MAXC = 2;

  logic clk = 0, rst = 1;
  logic rd_valid = 0, wr_valid = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [7:0] cancel_win = 0;
  logic rd_ready, rsp_valid, rsp_from_buf, wr_ready, cmd_valid, wr_done;
  logic [DW-1:0] rsp_data, cmd_data;
  logic [DW-1:0] bank_rdata = 0;
  logic [1:0] cmd_type;
  logic [AW-1:0] cmd_addr, wr_done_addr;

  pcm_wsched u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0, n_rd = 0, n_wr = 0, n_ab = 0, n_rsp = 0, n_done = 0;
  int last_rdcmd_cyc = 0, last_rsp_cyc = 0, last_done_cyc = 0;
  logic [DW-1:0] last_rsp_data;
  logic last_rsp_src;
  logic [AW-1:0] done_addr [64];

  // bank model: data follows the last read address from the next cycle
  always @(posedge clk)
    if (cmd_valid && cmd_type == 2'd0) bank_rdata <= cmd_addr ^ 8'h5A;

  always @(negedge clk) begin
    cyc++;
    if (cmd_valid) begin
      if (cmd_type == 2'd0) begin n_rd++; last_rdcmd_cyc = cyc; end
      else if (cmd_type == 2'd1) n_wr++;
      else if (cmd_type == 2'd2) n_ab++;
    end
    if (rsp_valid) begin
      n_rsp++; last_rsp_cyc = cyc; last_rsp_data = rsp_data; last_rsp_src = rsp_from_buf;
    end
    if (wr_done) begin
      done_addr[n_done % 64] = wr_done_addr; n_done++; last_done_cyc = cyc;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_rd(input logic [AW-1:0] a);
    while (!rd_ready) tick();
    rd_valid = 1; rd_addr = a;
    tick();
    rd_valid = 0;
  endtask

  task automatic send_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!wr_ready) tick();
    wr_valid = 1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 0;
  endtask

  task automatic wait_rsp(input int snap);
    while (n_rsp == snap) tick();
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) tick();
  endtask

  task automatic wait_wr_cmd();
    int s = n_wr;
    while (n_wr == s) tick();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s_rsp, s_rd, s_wr, s_ab, s_done;
    repeat (3) tick();
    rst = 0;
    tick();
    // reset state
    chk(rd_ready && wr_ready && !cmd_valid && !rsp_valid && !wr_done, "R1 reset idle", 0, 1);

    // R1 / R12: sweep bank reads
    for (int a = 0; a < 16; a++) begin
      s_rsp = n_rsp;
      send_rd(8'(a * 7 + 3));
      chk(!rd_ready || n_rsp != s_rsp, "R1 slot busy", rd_ready, 0);
      wait_rsp(s_rsp);
      chk(last_rsp_data == (8'(a * 7 + 3) ^ 8'h5A) && !last_rsp_src, "R1 bank data",
          last_rsp_data, (8'(a * 7 + 3) ^ 8'h5A));
      chk(last_rsp_cyc - last_rdcmd_cyc == RD_LAT, "R12 latency",
          last_rsp_cyc - last_rdcmd_cyc, RD_LAT);
    end

    // R2: buffer hit returns newest, no bank read
    cancel_win = 0;
    s_done = n_done;
    send_wr(8'h80, 8'h11);
    send_wr(8'h80, 8'h22);
    s_rd = n_rd; s_rsp = n_rsp;
    send_rd(8'h80);
    wait_rsp(s_rsp);
    chk(last_rsp_data == 8'h22 && last_rsp_src, "R2 newest buffered", last_rsp_data, 8'h22);
    chk(n_rd == s_rd, "R2 no bank read", n_rd - s_rd, 0);
    wait_done(s_done + 2);

    // R5 plain write, R9 window 0 -> pause (R8)
    s_wr = n_wr; s_ab = n_ab; s_done = n_done; s_rsp = n_rsp;
    send_wr(8'h41, 8'h99);
    wait_wr_cmd();
    send_rd(8'h07);
    wait_rsp(s_rsp);
    chk(last_rsp_data == (8'h07 ^ 8'h5A), "R8 paused read data", last_rsp_data, 8'h07 ^ 8'h5A);
    wait_done(s_done + 1);
    chk(last_rsp_cyc < last_done_cyc, "R4 read before write done", last_rsp_cyc, last_done_cyc);
    chk(n_ab == s_ab, "R9 window 0 no abort", n_ab - s_ab, 0);
    chk(n_wr - s_wr == ITERS, "R8 iterations kept", n_wr - s_wr, ITERS);
    chk(done_addr[(n_done - 1) % 64] == 8'h41, "R5 done addr", done_addr[(n_done - 1) % 64], 8'h41);

    // R6: early read cancels
    cancel_win = 20;
    s_wr = n_wr; s_ab = n_ab; s_done = n_done; s_rsp = n_rsp;
    send_wr(8'h42, 8'h33);
    wait_wr_cmd();
    send_rd(8'h09);
    wait_rsp(s_rsp);
    chk(last_rsp_data == (8'h09 ^ 8'h5A), "R6 read data", last_rsp_data, 8'h09 ^ 8'h5A);
    wait_done(s_done + 1);
    chk(n_ab - s_ab == 1, "R6 one abort", n_ab - s_ab, 1);
    chk(n_wr - s_wr == ITERS + 1, "R6 restart from zero", n_wr - s_wr, ITERS + 1);

    // R9: small window, late read -> pause
    cancel_win = 3;
    s_wr = n_wr; s_ab = n_ab; s_done = n_done;
    send_wr(8'h43, 8'h44);
    wait_wr_cmd();
    wait_wr_cmd();
    send_rd(8'h0B);
    wait_done(s_done + 1);
    chk(n_ab == s_ab, "R9 late read pauses", n_ab - s_ab, 0);
    chk(n_wr - s_wr == ITERS, "R9 iterations", n_wr - s_wr, ITERS);

    // R11: cancel allowance
    cancel_win = 20;
    s_wr = n_wr; s_ab = n_ab; s_done = n_done;
    send_wr(8'h44, 8'h55);
    for (int k = 0; k < 4; k++) begin
      wait_wr_cmd();
      s_rsp = n_rsp;
      send_rd(8'(k + 16));
      wait_rsp(s_rsp);
      chk(last_rsp_data == (8'(k + 16) ^ 8'h5A), "R11 read data", last_rsp_data, 8'(k + 16) ^ 8'h5A);
    end
    wait_done(s_done + 1);
    chk(n_ab - s_ab == MAXC, "R11 abort limit", n_ab - s_ab, MAXC);
    chk(n_wr - s_wr == ITERS + MAXC, "R11 iterations", n_wr - s_wr, ITERS + MAXC);

    // R3 / R10: fill buffer, no cancel while near full
    s_wr = n_wr; s_ab = n_ab; s_done = n_done; s_rsp = n_rsp;
    for (int k = 0; k < 4; k++) send_wr(8'(8'h60 + k), 8'(k));
    chk(!wr_ready, "R3 full", wr_ready, 0);
    send_rd(8'h0D);
    wait_rsp(s_rsp);
    chk(n_done == s_done, "R4 read served during writes", n_done - s_done, 0);
    wait_done(s_done + 4);
    chk(n_ab == s_ab, "R10 no abort near full", n_ab - s_ab, 0);
    chk(n_wr - s_wr == 4 * ITERS, "R5 iteration total", n_wr - s_wr, 4 * ITERS);
    for (int k = 0; k < 4; k++)
      chk(done_addr[(s_done + k) % 64] == 8'(8'h60 + k), "R5 done order",
          done_addr[(s_done + k) % 64], 8'h60 + k);
    chk(wr_ready, "R3 drained", wr_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule